// File: doc/BRIEF.md
# Initialization Block Fetch Sequencer

This block reads a controller's initialization block out of host memory as a bus master. A one-cycle start pulse hands it a base address. The fetch is then split into bus-mastership periods, and each period holds exactly two DWord reads. In each period the sequencer raises a bus request, waits for the grant, performs the two reads, and drops the request before the next period begins. Every DWord that is needed goes out on a write port into the initialization register file, tagged with its DWord index.

Two structure sizes are supported. The 16-bit layout takes six DWords, which is three periods. The 32-bit layout takes seven DWords, so four periods are used. The last read of the fourth period fetches an unused location, and its data is thrown away.

Two addressing modes are supported. In non-burst mode each read has its own address phase, and the frame signal falls between the two reads. In burst mode one address phase serves both reads, and its two low bits are zero to mark linear burst order.

An abort input ends the fetch at the next period boundary. From the cycle of the abort onward, no more register writes are made.

Top module: `initblk_fetch`

## Requirements
- R1: While reset is high and afterwards until a start is accepted, `req_o`, `frame_o`, `addr_valid_o`, `wr_en_o`, `done_o` and `busy_o` are all 0.
- R2: Every mastership period completes exactly two data phases (`rd_valid_i` high while `frame_o`=1 and `addr_valid_o`=0). `req_o` stays high from the start of the period until the second data phase completes, and is low on the next cycle. The only exception is an abort while waiting for grant.
- R3: With `wide_fmt_i`=1, a fetch uses 4 periods and 8 reads and produces 7 writes with indices 0 to 6. The data of the eighth read is not written.
- R4: With `wide_fmt_i`=0, a fetch uses 3 periods and 6 reads and produces 6 writes with indices 0 to 5.
- R5: With `burst_i`=0, each read has its own address phase. `frame_o` is low for at least one cycle between the two reads of a period, and the second address is the first plus 4.
- R6: With `burst_i`=1, each period has a single address phase. Its address has bits [2:0] equal to 0 relative to the aligned base, and `frame_o` stays high through both data phases.
- R7: The address of read k is (base with bits [1:0] cleared) + 4k. A misaligned base is rounded down.
- R8: The write with index k carries the data returned by the read of address aligned base + 4k. `wr_en_o` is high only in the cycle that data phase completes.
- R9: After `req_o` rises, no address phase starts until `gnt_i` has been sampled high. `req_o` stays high while waiting.
- R10: `done_o` pulses for one cycle after the last period's second data phase, and `busy_o` is low on the following cycle.
- R11: A start pulse and a changed base address presented while a fetch is in progress have no effect on the running fetch's addresses or writes.
- R12: An abort during a fetch lets the current period's bus reads finish, then returns to idle without starting another period. It suppresses every write from the abort cycle onward, and no `done_o` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| base_addr_i | input | AW | Byte address of the initialization block |
| wide_fmt_i | input | 1 | 1 = 32-bit structure layout, 0 = 16-bit |
| burst_i | input | 1 | 1 = burst addressing, 0 = one address per read |
| abort_i | input | 1 | Stop the fetch at the next period boundary |
| req_o | output | 1 | Bus request |
| gnt_i | input | 1 | Bus grant |
| frame_o | output | 1 | Transaction frame, high in address and data phases |
| addr_valid_o | output | 1 | Address phase marker |
| addr_o | output | AW | Address during an address phase, otherwise 0 |
| rd_valid_i | input | 1 | Data phase completes this cycle |
| rd_data_i | input | DW | Read data |
| wr_en_o | output | 1 | Register file write strobe |
| wr_idx_o | output | IDXW | DWord index of the write |
| wr_data_o | output | DW | Write data |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The checker assumes the following of the environment:
- `rd_valid_i` matters only in a data phase.
- Grant is not withdrawn in a way that the sequencer must react to.
- Abort is a single-cycle event.

The bench acts as both the arbiter and the memory target, and it drives inputs only through that role. It grants after a programmable delay. It raises `rd_valid_i` only while the sequencer shows a data phase, after a set number of wait states. It returns data computed from the address. It pulses abort exactly once, inside a data phase. It sweeps both structure sizes, both addressing modes, aligned and misaligned bases, and several grant and wait-state delays.

// File: rtl/initblk_pkg.sv
package initblk_pkg;

    localparam int unsigned READS_PER_PERIOD = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_ADDR,
        S_DATA,
        S_GAP,
        S_REL
    } seq_state_e;

    typedef struct packed {
        logic wide;
        logic burst;
    } fetch_cfg_t;

    function automatic int unsigned reads_for(input int unsigned dwords);
        return ((dwords + READS_PER_PERIOD - 1) / READS_PER_PERIOD) * READS_PER_PERIOD;
    endfunction

endpackage

// File: rtl/ifs_ctrl.sv
module ifs_ctrl
    import initblk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       gnt_i,
    input  logic       rd_valid_i,
    input  logic       abort_i,
    input  logic       wide_i,
    input  logic       burst_i,
    input  logic       all_read_i,
    output seq_state_e state_o,
    output fetch_cfg_t cfg_o,
    output logic       launch_o,
    output logic       beat_done_o,
    output logic       stop_o,
    output logic       done_o
);

    seq_state_e state_q, state_d;
    fetch_cfg_t cfg_q;
    logic       beat_q;
    logic       abort_q;
    logic       stop_now;

    assign launch_o    = (state_q == S_IDLE) && start_i;
    assign beat_done_o = (state_q == S_DATA) && rd_valid_i;
    assign stop_now    = abort_q || abort_i;
    assign stop_o      = stop_now;
    assign done_o      = (state_q == S_REL) && all_read_i && !stop_now;
    assign state_o     = state_q;
    assign cfg_o       = cfg_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start_i) state_d = S_REQ;
            S_REQ: begin
                if (stop_now)   state_d = S_IDLE;
                else if (gnt_i) state_d = S_ADDR;
            end
            S_ADDR: state_d = S_DATA;
            S_DATA: begin
                if (rd_valid_i) begin
                    if (beat_q)          state_d = S_REL;
                    else if (cfg_q.burst) state_d = S_DATA;
                    else                 state_d = S_GAP;
                end
            end
            S_GAP: state_d = S_ADDR;
            S_REL: begin
                if (stop_now || all_read_i) state_d = S_IDLE;
                else                        state_d = S_REQ;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cfg_q   <= '0;
            beat_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (launch_o) begin
                cfg_q.wide  <= wide_i;
                cfg_q.burst <= burst_i;
                beat_q      <= 1'b0;
                abort_q     <= 1'b0;
            end else begin
                if (beat_done_o)
                    beat_q <= !beat_q;
                if ((state_q != S_IDLE) && abort_i)
                    abort_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ifs_addr_gen.sv
module ifs_addr_gen #(
    parameter int unsigned AW           = 32,
    parameter int unsigned CNTW         = 4,
    parameter int unsigned WIDE_READS   = 8,
    parameter int unsigned NARROW_READS = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            launch_i,
    input  logic [AW-1:0]   base_i,
    input  logic            beat_done_i,
    input  logic            wide_i,
    output logic [CNTW-1:0] cnt_o,
    output logic [AW-1:0]   addr_o,
    output logic            all_read_o
);

    logic [AW-1:0]   base_q;
    logic [CNTW-1:0] cnt_q;
    logic [CNTW-1:0] limit;

    assign limit      = wide_i ? CNTW'(WIDE_READS) : CNTW'(NARROW_READS);
    assign all_read_o = (cnt_q == limit);
    assign cnt_o      = cnt_q;
    assign addr_o     = base_q + AW'({cnt_q, 2'b00});

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (launch_i) begin
            base_q <= base_i & ~AW'(3);
            cnt_q  <= '0;
        end else if (beat_done_i) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ifs_wr_gate.sv
module ifs_wr_gate #(
    parameter int unsigned DW            = 32,
    parameter int unsigned CNTW          = 4,
    parameter int unsigned IDXW          = 3,
    parameter int unsigned WIDE_DWORDS   = 7,
    parameter int unsigned NARROW_DWORDS = 6
) (
    input  logic            beat_done_i,
    input  logic [CNTW-1:0] cnt_i,
    input  logic            wide_i,
    input  logic            block_i,
    input  logic [DW-1:0]   data_i,
    output logic            wr_en_o,
    output logic [IDXW-1:0] wr_idx_o,
    output logic [DW-1:0]   wr_data_o
);

    logic [CNTW-1:0] keep_limit;
    logic            needed;

    assign keep_limit = wide_i ? CNTW'(WIDE_DWORDS) : CNTW'(NARROW_DWORDS);
    assign needed     = cnt_i < keep_limit;
    assign wr_en_o    = beat_done_i && needed && !block_i;
    assign wr_idx_o   = IDXW'(cnt_i);
    assign wr_data_o  = data_i;

endmodule

// File: rtl/initblk_fetch.sv
module initblk_fetch
    import initblk_pkg::*;
#(
    parameter int unsigned AW            = 32,
    parameter int unsigned DW            = 32,
    parameter int unsigned WIDE_DWORDS   = 7,
    parameter int unsigned NARROW_DWORDS = 6,
    parameter int unsigned IDXW          = $clog2(WIDE_DWORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [AW-1:0]   base_addr_i,
    input  logic            wide_fmt_i,
    input  logic            burst_i,
    input  logic            abort_i,
    output logic            req_o,
    input  logic            gnt_i,
    output logic            frame_o,
    output logic            addr_valid_o,
    output logic [AW-1:0]   addr_o,
    input  logic            rd_valid_i,
    input  logic [DW-1:0]   rd_data_i,
    output logic            wr_en_o,
    output logic [IDXW-1:0] wr_idx_o,
    output logic [DW-1:0]   wr_data_o,
    output logic            busy_o,
    output logic            done_o
);

    localparam int unsigned WIDE_READS   = reads_for(WIDE_DWORDS);
    localparam int unsigned NARROW_READS = reads_for(NARROW_DWORDS);
    localparam int unsigned CNTW         = $clog2(WIDE_READS + 1);

    seq_state_e      state;
    fetch_cfg_t      cfg;
    logic            launch;
    logic            beat_done;
    logic            stop;
    logic            all_read;
    logic [CNTW-1:0] cnt;
    logic [AW-1:0]   cur_addr;

    ifs_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .gnt_i       (gnt_i),
        .rd_valid_i  (rd_valid_i),
        .abort_i     (abort_i),
        .wide_i      (wide_fmt_i),
        .burst_i     (burst_i),
        .all_read_i  (all_read),
        .state_o     (state),
        .cfg_o       (cfg),
        .launch_o    (launch),
        .beat_done_o (beat_done),
        .stop_o      (stop),
        .done_o      (done_o)
    );

    ifs_addr_gen #(
        .AW           (AW),
        .CNTW         (CNTW),
        .WIDE_READS   (WIDE_READS),
        .NARROW_READS (NARROW_READS)
    ) u_addr (
        .clk         (clk),
        .rst         (rst),
        .launch_i    (launch),
        .base_i      (base_addr_i),
        .beat_done_i (beat_done),
        .wide_i      (cfg.wide),
        .cnt_o       (cnt),
        .addr_o      (cur_addr),
        .all_read_o  (all_read)
    );

    ifs_wr_gate #(
        .DW            (DW),
        .CNTW          (CNTW),
        .IDXW          (IDXW),
        .WIDE_DWORDS   (WIDE_DWORDS),
        .NARROW_DWORDS (NARROW_DWORDS)
    ) u_wr (
        .beat_done_i (beat_done),
        .cnt_i       (cnt),
        .wide_i      (cfg.wide),
        .block_i     (stop),
        .data_i      (rd_data_i),
        .wr_en_o     (wr_en_o),
        .wr_idx_o    (wr_idx_o),
        .wr_data_o   (wr_data_o)
    );

    assign req_o        = (state == S_REQ) || (state == S_ADDR) ||
                          (state == S_DATA) || (state == S_GAP);
    assign frame_o      = (state == S_ADDR) || (state == S_DATA);
    assign addr_valid_o = (state == S_ADDR);
    assign addr_o       = addr_valid_o ? cur_addr : '0;
    assign busy_o       = (state != S_IDLE);

endmodule

// File: rtl/ifs_chk.sv
module ifs_chk #(
    parameter int unsigned AW          = 32,
    parameter int unsigned IDXW        = 3,
    parameter int unsigned WIDE_DWORDS = 7
) (
    input logic            clk,
    input logic            rst,
    input logic            abort_i,
    input logic            req_o,
    input logic            frame_o,
    input logic            addr_valid_o,
    input logic [AW-1:0]   addr_o,
    input logic            rd_valid_i,
    input logic            wr_en_o,
    input logic [IDXW-1:0] wr_idx_o,
    input logic            busy_o,
    input logic            done_o
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!req_o && !frame_o && !wr_en_o));

    p_req_drop_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(req_o) |-> ($past(frame_o && !addr_valid_o && rd_valid_i) || $past(abort_i)));

    p_idx_range_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (int'(wr_idx_o) < WIDE_DWORDS));

    p_addr_aligned_r7: assert property (@(posedge clk) disable iff (rst)
        addr_valid_o |-> (addr_o[1:0] == 2'b00));

    p_wr_in_data_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (frame_o && !addr_valid_o && rd_valid_i));

    p_req_before_frame_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(req_o) |-> !frame_o);

    p_frame_in_req_r9: assert property (@(posedge clk) disable iff (rst)
        frame_o |-> req_o);

    p_done_then_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o));

endmodule

bind initblk_fetch ifs_chk #(
    .AW          (AW),
    .IDXW        (IDXW),
    .WIDE_DWORDS (WIDE_DWORDS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .abort_i      (abort_i),
    .req_o        (req_o),
    .frame_o      (frame_o),
    .addr_valid_o (addr_valid_o),
    .addr_o       (addr_o),
    .rd_valid_i   (rd_valid_i),
    .wr_en_o      (wr_en_o),
    .wr_idx_o     (wr_idx_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
);

// File: tb/test_initblk_fetch.sv
module test_initblk_fetch;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [AW-1:0] base_addr_i = '0;
    logic          wide_fmt_i = 1'b0;
    logic          burst_i = 1'b0;
    logic          abort_i = 1'b0;
    logic          req_o;
    logic          gnt_i = 1'b0;
    logic          frame_o;
    logic          addr_valid_o;
    logic [AW-1:0] addr_o;
    logic          rd_valid_i = 1'b0;
    logic [DW-1:0] rd_data_i = '0;
    logic          wr_en_o;
    logic [2:0]    wr_idx_o;
    logic [DW-1:0] wr_data_o;
    logic          busy_o;
    logic          done_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    initblk_fetch i_initblk_fetch (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .base_addr_i  (base_addr_i),
        .wide_fmt_i   (wide_fmt_i),
        .burst_i      (burst_i),
        .abort_i      (abort_i),
        .req_o        (req_o),
        .gnt_i        (gnt_i),
        .frame_o      (frame_o),
        .addr_valid_o (addr_valid_o),
        .addr_o       (addr_o),
        .rd_valid_i   (rd_valid_i),
        .rd_data_i    (rd_data_i),
        .wr_en_o      (wr_en_o),
        .wr_idx_o     (wr_idx_o),
        .wr_data_o    (wr_data_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h0BADF00D;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_fetch(input bit wide, input bit burst, input logic [31:0] base,
                             input int gd, input int ws, input bit do_abort);
        int periods   = wide ? 4 : 3;
        int dwords    = wide ? 7 : 6;
        logic [31:0] abase = base & ~32'h3;
        int req_rises = 0, frame_rises = 0, aphases = 0, reads = 0, writes = 0, dones = 0;
        logic prev_req = 1'b0, prev_frame = 1'b0, last_gnt = 1'b0, first_av = 1'b0;
        logic [31:0] cur_addr = '0;
        int gcnt = 0, wcnt = 0;
        bit aborted = 1'b0, poked = 1'b0;
        logic r, f, av, rv;

        @(negedge clk);
        wide_fmt_i  = wide;
        burst_i     = burst;
        base_addr_i = base;
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;

        for (int cyc = 0; cyc < 400; cyc++) begin
            r  = req_o;
            f  = frame_o;
            av = addr_valid_o;
            if (!busy_o) break;
            if (r) gcnt++; else gcnt = 0;
            gnt_i = r && (gcnt > gd);
            if (f && !av) begin
                wcnt++;
                rv = (wcnt > ws);
            end else begin
                wcnt = 0;
                rv = 1'b0;
            end
            rd_valid_i = rv;
            rd_data_i  = rv ? mem_word(cur_addr) : 32'hDEAD_BEEF;
            if (do_abort && !aborted && f && !av && reads == 3) begin
                abort_i = 1'b1;
                aborted = 1'b1;
            end else begin
                abort_i = 1'b0;
            end
            if (!poked && reads == 2) begin
                start_i     = 1'b1;
                base_addr_i = base + 32'h400;
                poked       = 1'b1;
            end else begin
                start_i     = 1'b0;
                base_addr_i = base;
            end
            #1;
            if (r && !prev_req) begin
                req_rises++;
                first_av = 1'b1;
            end
            if (f && !prev_frame) frame_rises++;
            if (av) begin
                aphases++;
                cur_addr = addr_o;
                check(addr_o == abase + 32'(4 * reads), "R7/R11 address", addr_o,
                      abase + 32'(4 * reads));
                if (burst)
                    check(((addr_o - abase) & 32'h7) == 0, "R6 burst address bits", addr_o - abase, 0);
                if (first_av) begin
                    check(last_gnt == 1'b1, "R9 grant before address", {31'b0, last_gnt}, 1);
                    first_av = 1'b0;
                end
            end
            if (rv) begin
                reads++;
                cur_addr = cur_addr + 4;
            end
            if (wr_en_o) begin
                check(wr_idx_o == 3'(writes), "R8 write index", {29'b0, wr_idx_o}, writes);
                check(wr_data_o == mem_word(abase + 32'(4 * writes)), "R8 write data",
                      wr_data_o, mem_word(abase + 32'(4 * writes)));
                writes++;
            end
            if (done_o) begin
                dones++;
                check(writes == dwords, "R10 done after all writes", writes, dwords);
            end
            last_gnt   = gnt_i;
            prev_req   = r;
            prev_frame = f;
            @(negedge clk);
        end
        gnt_i = 1'b0; rd_valid_i = 1'b0; abort_i = 1'b0; start_i = 1'b0;
        #1;
        check(!busy_o && !req_o, "R10/R12 idle at end", {31'b0, busy_o}, 0);
        if (do_abort) begin
            check(writes == 3, "R12 writes stop at abort", writes, 3);
            check(req_rises == 2, "R12 no new period", req_rises, 2);
            check(dones == 0, "R12 no done", dones, 0);
            check(reads == 4, "R12 period reads finish", reads, 4);
        end else begin
            check(req_rises == periods, wide ? "R3 periods" : "R4 periods", req_rises, periods);
            check(reads == 2 * periods, "R2 two reads per period", reads, 2 * periods);
            check(writes == dwords, wide ? "R3 writes" : "R4 writes", writes, dwords);
            check(dones == 1, "R10 one done pulse", dones, 1);
            if (burst) begin
                check(aphases == periods, "R6 one address per period", aphases, periods);
                check(frame_rises == periods, "R6 frame held", frame_rises, periods);
            end else begin
                check(aphases == 2 * periods, "R5 address per read", aphases, 2 * periods);
                check(frame_rises == 2 * periods, "R5 frame gap", frame_rises, 2 * periods);
            end
        end
    endtask

    initial begin
        logic [31:0] bases [3];
        bases[0] = 32'h0000_1000;
        bases[1] = 32'h0000_2003;
        bases[2] = 32'h8000_0FF6;
        repeat (3) @(negedge clk);
        check(!req_o && !frame_o && !addr_valid_o && !wr_en_o && !done_o && !busy_o,
              "R1 outputs in reset", {31'b0, req_o | busy_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!req_o && !busy_o && !done_o, "R1 idle after reset", {31'b0, busy_o}, 0);
        for (int w = 0; w < 2; w++)
            for (int b = 0; b < 2; b++)
                for (int k = 0; k < 3; k++)
                    for (int g = 0; g < 3; g += 2)
                        for (int s = 0; s < 2; s++)
                            run_fetch(w[0], b[0], bases[k], g, s, 1'b0);
        for (int w = 0; w < 2; w++)
            for (int b = 0; b < 2; b++)
                for (int s = 0; s < 2; s++)
                    run_fetch(w[0], b[0], bases[1], 1, s, 1'b1);
        run_fetch(1'b1, 1'b0, bases[0], 0, 0, 1'b0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule